// File: doc/BRIEF.md
# I2C Slave Event and Clock-Stretch Controller

This block is the slave-side event logic that sits between the bit-level front end of an I2C interface and the CPU register file. The front end reports decoded bus events as single-cycle pulses: an address byte has been shifted in, an acknowledge slot has ended, a data byte together with its acknowledge has completed, a STOP was seen, and arbitration was lost. The block decides which of these events interrupt the CPU. It issues a one-clock interrupt pulse and clears an active-low pending flag.

While the flag is clear, the block asks the pad logic to hold SCL low, which stalls the bus until software services the byte. Software releases the stall by touching the data register or by writing a 1 to the flag. SCL is then kept low for a further programmable number of clocks before it is let go. A 2-bit mode field enables the bus logic. Every other mode value leaves the bus logic inert.

Top module: `i2c_slave_event_ctrl`

## Requirements
- R1: In I2C mode, the address byte is captured on `ev_addr_rx`. Bits [7:1] are the address and bit 0 is the direction. If bits [7:1] equal `own_addr`, the next `ev_ack_end` raises the interrupt, clears `pin` and sets `addressed`. A non-matching byte raises nothing.
- R2: An address byte of exactly 8'h00 is a general call. The next `ev_ack_end` raises the interrupt, clears `pin`, and sets both `addressed` and `gcall`.
- R3: While `addressed` is set, every `ev_byte_done` raises the interrupt and clears `pin`. While it is clear, `ev_byte_done` is ignored.
- R4: Whenever the interrupt is raised by an address or byte event, `pin` goes to 0. In I2C mode, `scl_hold` is 1 for as long as `pin` is 0. `pin` resets to 1.
- R5: A pulse on `cpu_dat_wr` or `cpu_dat_rd` sets `pin` to 1 on the next clock.
- R6: A control write (`cpu_ctl_wr`) with `cpu_pin_wdata`=1 sets `pin`. With `cpu_pin_wdata`=0 it leaves `pin` unchanged.
- R7: After `pin` rises, `scl_hold` stays 1 for exactly `TLOW` further clocks and then drops.
- R8: `ev_arb_lost` raises the interrupt and leaves `pin` at its previous value.
- R9: Only `mode`=2'b10 enables the bus logic. With any other value, bus events raise no interrupt, `scl_hold` is 0, and `addressed`/`gcall` are cleared.
- R10: A new interrupt during the release countdown clears `pin` again, and SCL stays held until the next release.
- R11: `irq` is a one-clock pulse, registered on the clock edge that samples the event.
- R12: `ev_stop` clears `addressed` and `gcall`, so later `ev_byte_done` pulses raise nothing.
- R13: If a hardware clear of `pin` and a software or data-access set of `pin` fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Bus mode field; 2'b10 enables I2C |
| own_addr | input | ADDR_W | Programmed own slave address |
| addr_byte | input | ADDR_W+1 | Received address byte, valid with `ev_addr_rx` |
| ev_addr_rx | input | 1 | Address byte received pulse |
| ev_ack_end | input | 1 | End of an acknowledge slot pulse |
| ev_byte_done | input | 1 | Data byte plus acknowledge completed pulse |
| ev_stop | input | 1 | STOP condition pulse |
| ev_arb_lost | input | 1 | Arbitration lost, foreign address not matching |
| cpu_dat_wr | input | 1 | CPU write to the data register |
| cpu_dat_rd | input | 1 | CPU read of the data register |
| cpu_ctl_wr | input | 1 | CPU write to the control register |
| cpu_pin_wdata | input | 1 | Value written to the pending flag on `cpu_ctl_wr` |
| irq | output | 1 | One-clock interrupt request |
| pin | output | 1 | Pending flag, 0 while an interrupt is unserviced |
| scl_hold | output | 1 | Request to drive SCL low |
| addressed | output | 1 | Slave currently selected |
| gcall | output | 1 | Selection came from a general call |

## Verification
The bench builds the block with `TLOW`=4. This is long enough that the countdown can be sampled clock by clock and interrupted part way through, yet short enough that every release is observed to its end. `ADDR_W` stays at 7, which exercises the full address compare against a single fixed own address, including neighbouring addresses and the direction bit.

// File: rtl/i2c_sev_pkg.sv
package i2c_sev_pkg;

    localparam logic [1:0] MODE_I2C = 2'b10;

    typedef struct packed {
        logic pin;
        logic irq;
        logic addressed;
        logic gcall;
        logic pend_hit;
        logic pend_gc;
    } sev_state_t;

    localparam sev_state_t SEV_RESET = '{
        pin:       1'b1,
        irq:       1'b0,
        addressed: 1'b0,
        gcall:     1'b0,
        pend_hit:  1'b0,
        pend_gc:   1'b0
    };

endpackage

// File: rtl/i2c_sev_addr_cmp.sv
module i2c_sev_addr_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W:0]   addr_byte,
    output logic              hit,
    output logic              gc
);
    // Address field sits above the direction bit.
    always_comb begin
        hit = (addr_byte[ADDR_W:1] == own_addr);
        gc  = (addr_byte == '0);
    end
endmodule

// File: rtl/i2c_sev_stall_timer.sv
module i2c_sev_stall_timer #(
    parameter int TLOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic kill_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(TLOW + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TLOW);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kill_i) begin
            cnt_d = '0;
        end else if (load_i) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_slave_event_ctrl.sv
module i2c_slave_event_ctrl
    import i2c_sev_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int TLOW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W:0]   addr_byte,
    input  logic              ev_addr_rx,
    input  logic              ev_ack_end,
    input  logic              ev_byte_done,
    input  logic              ev_stop,
    input  logic              ev_arb_lost,
    input  logic              cpu_dat_wr,
    input  logic              cpu_dat_rd,
    input  logic              cpu_ctl_wr,
    input  logic              cpu_pin_wdata,
    output logic              irq,
    output logic              pin,
    output logic              scl_hold,
    output logic              addressed,
    output logic              gcall
);
    sev_state_t st_d, st_q;
    logic       active;
    logic       hit, gc;
    logic       raise;
    logic       sw_set;
    logic       tmr_busy;

    i2c_sev_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .own_addr (own_addr),
        .addr_byte(addr_byte),
        .hit      (hit),
        .gc       (gc)
    );

    always_comb begin
        active = (mode == MODE_I2C);
        sw_set = cpu_dat_wr | cpu_dat_rd | (cpu_ctl_wr & cpu_pin_wdata);
        raise  = 1'b0;
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (!active) begin
            st_d.addressed = 1'b0;
            st_d.gcall     = 1'b0;
            st_d.pend_hit  = 1'b0;
            st_d.pend_gc   = 1'b0;
        end else begin
            if (ev_addr_rx) begin
                st_d.addressed = 1'b0;
                st_d.gcall     = 1'b0;
                st_d.pend_hit  = hit | gc;
                st_d.pend_gc   = gc;
            end else if (ev_ack_end) begin
                if (st_q.pend_hit) begin
                    raise          = 1'b1;
                    st_d.addressed = 1'b1;
                    st_d.gcall     = st_q.pend_gc;
                end
                st_d.pend_hit = 1'b0;
                st_d.pend_gc  = 1'b0;
            end else if (ev_byte_done && st_q.addressed) begin
                raise = 1'b1;
            end

            if (ev_stop) begin
                st_d.addressed = 1'b0;
                st_d.gcall     = 1'b0;
                st_d.pend_hit  = 1'b0;
                st_d.pend_gc   = 1'b0;
            end
            st_d.irq = raise | ev_arb_lost;
        end

        // Software may only set the flag; a hardware clear takes precedence.
        if (sw_set) st_d.pin = 1'b1;
        if (raise)  st_d.pin = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEV_RESET;
        else        st_q <= st_d;
    end

    i2c_sev_stall_timer #(.TLOW(TLOW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(st_d.pin & ~st_q.pin),
        .kill_i(~st_d.pin),
        .busy_o(tmr_busy)
    );

    assign irq       = st_q.irq;
    assign pin       = st_q.pin;
    assign addressed = st_q.addressed;
    assign gcall     = st_q.gcall;
    assign scl_hold  = active & (~st_q.pin | tmr_busy);
endmodule

// File: rtl/i2c_slave_event_ctrl_chk.sv
module i2c_slave_event_ctrl_chk #(
    parameter int TLOW = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       ev_ack_end,
    input logic       ev_byte_done,
    input logic       ev_stop,
    input logic       ev_arb_lost,
    input logic       cpu_dat_wr,
    input logic       cpu_dat_rd,
    input logic       cpu_ctl_wr,
    input logic       irq,
    input logic       pin,
    input logic       scl_hold,
    input logic       addressed
);
    localparam int CW = $clog2(TLOW + 2);
    logic [CW-1:0] rel_cnt;

    // Counts clocks spent holding SCL after the flag is set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rel_cnt <= '0;
        else if (pin && scl_hold) begin
            if (rel_cnt != '1)      rel_cnt <= rel_cnt + 1'b1;
        end else                    rel_cnt <= '0;
    end

    p_hold_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !pin) |-> scl_hold);

    p_fall_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin) |-> irq);

    p_access_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_dat_wr || cpu_dat_rd) && !ev_ack_end && !ev_byte_done) |=> pin);

    p_rise_still_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin) && mode == 2'b10) |-> scl_hold);

    p_release_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cnt <= CW'(TLOW));

    p_arb_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_arb_lost && mode == 2'b10 && !ev_ack_end && !ev_byte_done
         && !cpu_dat_wr && !cpu_dat_rd && !cpu_ctl_wr)
        |=> (irq && pin == $past(pin)));

    p_inactive_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b10) |=> !irq);

    p_stop_deselects_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !addressed);
endmodule

bind i2c_slave_event_ctrl i2c_slave_event_ctrl_chk #(.TLOW(TLOW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .ev_ack_end  (ev_ack_end),
    .ev_byte_done(ev_byte_done),
    .ev_stop     (ev_stop),
    .ev_arb_lost (ev_arb_lost),
    .cpu_dat_wr  (cpu_dat_wr),
    .cpu_dat_rd  (cpu_dat_rd),
    .cpu_ctl_wr  (cpu_ctl_wr),
    .irq         (irq),
    .pin         (pin),
    .scl_hold    (scl_hold),
    .addressed   (addressed)
);

// File: tb/test_i2c_slave_event_ctrl.sv
module test_i2c_slave_event_ctrl;
    localparam int ADDR_W = 7;
    localparam int TLOW   = 4;
    localparam logic [6:0] OWN = 7'h5A;

    // {address byte, expect interrupt, expect general call}
    localparam logic [9:0] VEC [0:6] = '{
        {8'hB4, 1'b1, 1'b0},
        {8'hB5, 1'b1, 1'b0},
        {8'h00, 1'b1, 1'b1},
        {8'h01, 1'b0, 1'b0},
        {8'hB6, 1'b0, 1'b0},
        {8'h5A, 1'b0, 1'b0},
        {8'hFE, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [7:0] addr_byte = '0;
    logic ev_addr_rx = 0, ev_ack_end = 0, ev_byte_done = 0, ev_stop = 0, ev_arb_lost = 0;
    logic cpu_dat_wr = 0, cpu_dat_rd = 0, cpu_ctl_wr = 0, cpu_pin_wdata = 0;
    logic irq, pin, scl_hold, addressed, gcall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_slave_event_ctrl #(.ADDR_W(ADDR_W), .TLOW(TLOW)) i_i2c_slave_event_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .own_addr(OWN), .addr_byte(addr_byte),
        .ev_addr_rx(ev_addr_rx), .ev_ack_end(ev_ack_end), .ev_byte_done(ev_byte_done),
        .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost), .cpu_dat_wr(cpu_dat_wr),
        .cpu_dat_rd(cpu_dat_rd), .cpu_ctl_wr(cpu_ctl_wr), .cpu_pin_wdata(cpu_pin_wdata),
        .irq(irq), .pin(pin), .scl_hold(scl_hold), .addressed(addressed), .gcall(gcall)
    );

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_addr(logic [7:0] b);
        addr_byte = b; ev_addr_rx = 1; step(); ev_addr_rx = 0;
        ev_ack_end = 1; step(); ev_ack_end = 0;
    endtask

    task automatic pulse_byte(); ev_byte_done = 1; step(); ev_byte_done = 0; endtask
    task automatic pulse_stop(); ev_stop = 1; step(); ev_stop = 0; endtask
    task automatic pulse_rd();   cpu_dat_rd = 1; step(); cpu_dat_rd = 0; endtask
    task automatic pulse_wr();   cpu_dat_wr = 1; step(); cpu_dat_wr = 0; endtask
    task automatic pulse_arb();  ev_arb_lost = 1; step(); ev_arb_lost = 0; endtask
    task automatic ctl_write(logic v);
        cpu_ctl_wr = 1; cpu_pin_wdata = v; step(); cpu_ctl_wr = 0; cpu_pin_wdata = 0;
    endtask
    task automatic settle(); repeat (TLOW + 1) step(); endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        check("R4", "reset pin", pin, 1'b1);
        check("R11", "reset irq", irq, 1'b0);
        check("R4", "reset hold", scl_hold, 1'b0);
        check("R1", "reset addressed", addressed, 1'b0);
        rst_n = 1; step();

        // Address table: R1 own address, R2 general call
        for (int i = 0; i < 7; i++) begin
            send_addr(VEC[i][9:2]);
            check(VEC[i][0] ? "R2" : "R1", "irq after ack", irq, VEC[i][1]);
            check("R1", "pin after ack", pin, ~VEC[i][1]);
            check("R1", "addressed", addressed, VEC[i][1]);
            check("R2", "gcall", gcall, VEC[i][0]);
            if (VEC[i][1]) begin
                check("R4", "hold while pending", scl_hold, 1'b1);
                pulse_rd();
                check("R5", "read sets pin", pin, 1'b1);
                settle();
            end
            pulse_stop();
        end

        // R7 release timing, R3 byte interrupt, R11 pulse width
        send_addr(8'hB4);
        step();
        check("R11", "irq one clock", irq, 1'b0);
        pulse_wr();
        check("R5", "write sets pin", pin, 1'b1);
        check("R7", "hold at release start", scl_hold, 1'b1);
        repeat (TLOW - 1) step();
        check("R7", "hold at last tLOW clock", scl_hold, 1'b1);
        step();
        check("R7", "released after tLOW", scl_hold, 1'b0);
        pulse_byte();
        check("R3", "byte irq", irq, 1'b1);
        check("R3", "byte clears pin", pin, 1'b0);
        step();
        check("R11", "byte irq one clock", irq, 1'b0);

        // R6 software write
        ctl_write(1'b0);
        check("R6", "write 0 ignored", pin, 1'b0);
        check("R6", "still held", scl_hold, 1'b1);
        ctl_write(1'b1);
        check("R6", "write 1 sets", pin, 1'b1);

        // R10 interrupt during countdown
        step();
        pulse_byte();
        check("R10", "pin cleared in countdown", pin, 1'b0);
        repeat (TLOW + 2) step();
        check("R10", "held past old countdown", scl_hold, 1'b1);

        // R13 same-cycle clear beats set
        pulse_rd(); settle();
        ev_byte_done = 1; cpu_dat_rd = 1; step(); ev_byte_done = 0; cpu_dat_rd = 0;
        check("R13", "clear wins", pin, 1'b0);
        pulse_rd(); settle();

        // R8 arbitration lost
        pulse_arb();
        check("R8", "arb irq", irq, 1'b1);
        check("R8", "arb keeps pin 1", pin, 1'b1);
        pulse_byte();
        pulse_arb();
        check("R8", "arb keeps pin 0", pin, 1'b0);
        pulse_wr(); settle();

        // R12 stop deselects
        pulse_stop();
        check("R12", "stop clears addressed", addressed, 1'b0);
        pulse_byte();
        check("R12", "byte after stop no irq", irq, 1'b0);
        check("R12", "byte after stop pin", pin, 1'b1);

        // R9 inactive modes
        mode = 2'b01; step();
        send_addr(8'hB4);
        check("R9", "no irq when inactive", irq, 1'b0);
        check("R9", "no address when inactive", addressed, 1'b0);
        mode = 2'b10; step();
        send_addr(8'hB4);
        check("R9", "active pin cleared", pin, 1'b0);
        mode = 2'b00; #1;
        check("R9", "hold dropped when inactive", scl_hold, 1'b0);
        step();
        check("R9", "addressed cleared", addressed, 1'b0);
        pulse_byte();
        check("R9", "byte ignored inactive", irq, 1'b0);
        ctl_write(1'b1);
        mode = 2'b10; settle();
        check("R7", "final released", scl_hold, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule